// File: doc/BRIEF.md
# Caption Character Pixel Renderer

This block turns one pixel position inside a caption character cell into display colour and a blanking signal. Each clock it receives the cell-relative column and scan line, the bitmap of the glyph row that falls on that scan line, the bitmap of the glyph row one scan line higher, and the 4-bit attribute code in force from the row-start or mid-row codes. It places the glyph inside its cell, slants it for italics, draws an underline, and fills the rest of the cell according to the selected display style: a black box, a see-through video background, or a checkerboard mesh. In the enhanced styles it can also add a black drop shadow.

A small configuration register holds the display mode, the enhanced style and the output polarity. The polarity inversion applies only to the caption path. An external on-screen display can take over the outputs pixel by pixel. While its blanking input is high, its colour is passed straight through. When that input falls, caption output continues with no state lost. All outputs come from one register stage, so a result appears one clock after its inputs.

Top module: `ccr_pixel_render`

## Requirements
- R1: A cell is 7 columns (0..6) by 13 scan lines (0..12). The glyph fills columns 1..5 and lines 1..12. On line y the glyph_row input holds glyph row y-1, and its bit 4 is the leftmost glyph column (cell column 1). Column 0, and all of line 0, carry no glyph pixel, whatever the bitmap inputs hold.
- R2: attr_code[3:1] selects the foreground colour as {red,green,blue}: 0 white 111, 1 green 010, 2 blue 001, 3 cyan 011, 4 red 100, 5 yellow 110, 6 magenta 101, 7 white 111 with italics. Lit pixels show this colour with blanking active.
- R3: attr_code[0]=1 lights all seven columns of line 12 in the foreground colour.
- R4: With italics, the glyph pixels on line y move right by (12-y)/4 columns, using integer division. Pixels pushed past column 6 are dropped.
- R5: cfg_mode encodes 00 video only, 01 text, 10 normal caption and 11 enhanced caption. Video only gives rgb 000 with blanking inactive. Text and normal caption draw normal characters: every unlit pixel of the cell is black with blanking active.
- R6: In enhanced caption mode, cfg_style[1]=0 selects shadowed characters and 1 selects normal characters. cfg_style[0]=0 makes unlit pixels transparent (blanking inactive, rgb 000). cfg_style[0]=1 selects a mesh: an unlit pixel with an even x+y is black with blanking active, and one with an odd x+y is transparent.
- R7: In shadowed style, an unlit pixel (x,y) whose neighbour (x-1,y-1) is lit shows black with blanking active. glyph_above holds the bitmap for line y-1, that is glyph row y-2, and that row takes the italic shift of line y-1.
- R8: cfg_invert=1 inverts all three colour outputs and the blanking output of the caption path.
- R9: While osd_blank is high, vid_rgb equals osd_rgb and vid_blank is 1, whatever the mode or polarity. On the next pixel after osd_blank falls, the caption output resumes.
- R10: cfg_mode, cfg_style and cfg_invert are loaded only on a clock with cfg_we=1. Reset clears all three fields to zero, which selects video-only mode, and clears the outputs to zero.
- R11: vid_rgb and vid_blank are registered and reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_mode | input | 2 | Display mode code |
| cfg_style | input | 2 | Enhanced style code (shadow, mesh) |
| cfg_invert | input | 1 | Caption output polarity, 1 = negative-going |
| pix_x | input | 3 | Column inside the cell, 0..6 |
| pix_y | input | 4 | Scan line inside the cell, 0..12 |
| glyph_row | input | 5 | Glyph bitmap for the current line, bit 4 leftmost |
| glyph_above | input | 5 | Glyph bitmap for the line above |
| attr_code | input | 4 | Colour / italics / underline attribute code |
| osd_blank | input | 1 | External display blanking; high takes over the outputs |
| osd_rgb | input | 3 | External display colour |
| vid_rgb | output | 3 | Colour output {red,green,blue} |
| vid_blank | output | 1 | Blanking output |

## Verification
The bench sweeps every pixel of the cell through every mode, style, polarity and attribute code, and compares each output with an arithmetic model. Italic slant is the main target. A design that shifted the wrong rows, or failed to drop pixels pushed past column 6, would light stray pixels on the right edge. The bench loads deliberate garbage into the bitmaps on lines 0 and 1, where the row above does not exist. A renderer that read those bitmaps would paint spurious glyph or shadow pixels. Short external-display pulses scattered through the sweep catch an overlay that applied the caption polarity or held the previous value after takeover. A directed sequence checks the one-clock latency, that configuration changes are ignored without the load strobe, and that a mid-run reset returns the block to video only.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int RGB_W = 3;

   typedef logic [RGB_W-1:0] rgb_t;

   typedef enum logic [1:0] {
      DM_VIDEO    = 2'b00,
      DM_TEXT     = 2'b01,
      DM_CAPTION  = 2'b10,
      DM_ENHANCED = 2'b11
   } disp_mode_e;

   localparam rgb_t RGB_BLACK   = 3'b000;
   localparam rgb_t RGB_WHITE   = 3'b111;
   localparam rgb_t RGB_GREEN   = 3'b010;
   localparam rgb_t RGB_BLUE    = 3'b001;
   localparam rgb_t RGB_CYAN    = 3'b011;
   localparam rgb_t RGB_RED     = 3'b100;
   localparam rgb_t RGB_YELLOW  = 3'b110;
   localparam rgb_t RGB_MAGENTA = 3'b101;

   typedef struct packed {
      rgb_t fg;
      logic italic;
      logic uline;
   } attr_t;

endpackage

// File: rtl/ccr_attr_decode.sv
module ccr_attr_decode
   import ccr_pkg::*;
(
   input  logic [3:0] code,
   output attr_t      attr
);

   always_comb begin
      attr.uline  = code[0];
      attr.italic = 1'b0;
      unique case (code[3:1])
         3'd0: attr.fg = RGB_WHITE;
         3'd1: attr.fg = RGB_GREEN;
         3'd2: attr.fg = RGB_BLUE;
         3'd3: attr.fg = RGB_CYAN;
         3'd4: attr.fg = RGB_RED;
         3'd5: attr.fg = RGB_YELLOW;
         3'd6: attr.fg = RGB_MAGENTA;
         default: begin
            attr.fg     = RGB_WHITE;
            attr.italic = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/ccr_glyph_tap.sv
module ccr_glyph_tap #(
   parameter int GLYPH_W   = 5,
   parameter int GLYPH_H   = 12,
   parameter int ITAL_STEP = 4,
   parameter int XW        = 3,
   parameter int YW        = 4
)(
   input  logic [GLYPH_W-1:0] bits,
   input  logic [XW-1:0]      px,
   input  logic [YW-1:0]      py,
   input  logic               italic,
   input  logic               valid,
   output logic               lit
);

   localparam int BASE_LINE = GLYPH_H;
   localparam int SW        = XW + 1;
   localparam int PW        = XW + 2;

   logic [YW-1:0]      rise;
   logic [SW-1:0]      shift;
   logic [GLYPH_W-1:0] hit;

   always_comb begin
      rise  = YW'(BASE_LINE) - py;
      shift = italic ? SW'(rise / YW'(ITAL_STEP)) : '0;
   end

   for (genvar c = 0; c < GLYPH_W; c++) begin : g_col
      logic [PW-1:0] pos;
      assign pos    = PW'(c + 1) + PW'(shift);
      assign hit[c] = bits[GLYPH_W-1-c] && (pos == PW'(px));
   end

   assign lit = valid && (py != '0) && (|hit);

endmodule

// File: rtl/ccr_compose.sv
module ccr_compose
   import ccr_pkg::*;
(
   input  disp_mode_e mode,
   input  logic [1:0] style,
   input  logic       invert,
   input  logic       fg_on,
   input  logic       shade,
   input  logic       mesh_dark,
   input  rgb_t       fg,
   output rgb_t       rgb,
   output logic       blank
);

   rgb_t raw_rgb;
   logic raw_blank;
   logic shadow_en;
   logic mesh_en;

   assign shadow_en = ~style[1];
   assign mesh_en   = style[0];

   always_comb begin
      raw_rgb   = RGB_BLACK;
      raw_blank = 1'b0;
      unique case (mode)
         DM_VIDEO: begin
            raw_rgb   = RGB_BLACK;
            raw_blank = 1'b0;
         end
         DM_TEXT, DM_CAPTION: begin
            raw_rgb   = fg_on ? fg : RGB_BLACK;
            raw_blank = 1'b1;
         end
         default: begin
            if (fg_on) begin
               raw_rgb   = fg;
               raw_blank = 1'b1;
            end else if (shadow_en && shade) begin
               raw_blank = 1'b1;
            end else if (mesh_en && mesh_dark) begin
               raw_blank = 1'b1;
            end
         end
      endcase
      rgb   = raw_rgb ^ {RGB_W{invert}};
      blank = raw_blank ^ invert;
   end

endmodule

// File: rtl/ccr_pixel_render.sv
module ccr_pixel_render
   import ccr_pkg::*;
#(
   parameter  int GLYPH_W   = 5,
   parameter  int GLYPH_H   = 12,
   parameter  int ITAL_STEP = 4,
   localparam int CELL_W    = GLYPH_W + 2,
   localparam int CELL_H    = GLYPH_H + 1,
   localparam int XW        = $clog2(CELL_W),
   localparam int YW        = $clog2(CELL_H)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_mode,
   input  logic [1:0]         cfg_style,
   input  logic               cfg_invert,
   input  logic [XW-1:0]      pix_x,
   input  logic [YW-1:0]      pix_y,
   input  logic [GLYPH_W-1:0] glyph_row,
   input  logic [GLYPH_W-1:0] glyph_above,
   input  logic [3:0]         attr_code,
   input  logic               osd_blank,
   input  logic [RGB_W-1:0]   osd_rgb,
   output logic [RGB_W-1:0]   vid_rgb,
   output logic               vid_blank
);

   if (GLYPH_W < 1 || GLYPH_H < 2) begin : g_bad_glyph
      $error("glyph must be at least 1 column by 2 rows");
   end
   if (ITAL_STEP < 1) begin : g_bad_step
      $error("italic step must be positive");
   end

   disp_mode_e mode_q;
   logic [1:0] style_q;
   logic       inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= DM_VIDEO;
         style_q <= '0;
         inv_q   <= 1'b0;
      end else if (cfg_we) begin
         mode_q  <= disp_mode_e'(cfg_mode);
         style_q <= cfg_style;
         inv_q   <= cfg_invert;
      end
   end

   attr_t attr;

   ccr_attr_decode u_attr (
      .code (attr_code),
      .attr (attr)
   );

   logic          in_cell;
   logic          has_above;
   logic [XW-1:0] left_x;
   logic [YW-1:0] up_y;
   logic          lit_here;
   logic          lit_diag;

   assign in_cell   = (pix_x < XW'(CELL_W)) && (pix_y < YW'(CELL_H));
   assign has_above = in_cell && (pix_x != '0) && (pix_y != '0);
   assign left_x    = pix_x - XW'(1);
   assign up_y      = pix_y - YW'(1);

   ccr_glyph_tap #(
      .GLYPH_W (GLYPH_W), .GLYPH_H (GLYPH_H), .ITAL_STEP (ITAL_STEP),
      .XW (XW), .YW (YW)
   ) u_tap_here (
      .bits   (glyph_row),
      .px     (pix_x),
      .py     (pix_y),
      .italic (attr.italic),
      .valid  (in_cell),
      .lit    (lit_here)
   );

   ccr_glyph_tap #(
      .GLYPH_W (GLYPH_W), .GLYPH_H (GLYPH_H), .ITAL_STEP (ITAL_STEP),
      .XW (XW), .YW (YW)
   ) u_tap_diag (
      .bits   (glyph_above),
      .px     (left_x),
      .py     (up_y),
      .italic (attr.italic),
      .valid  (has_above),
      .lit    (lit_diag)
   );

   logic uline_px;
   logic fg_on;
   logic mesh_dark;

   assign uline_px  = attr.uline && in_cell && (pix_y == YW'(CELL_H - 1));
   assign fg_on     = lit_here || uline_px;
   assign mesh_dark = ~(pix_x[0] ^ pix_y[0]);

   rgb_t cap_rgb;
   logic cap_blank;

   ccr_compose u_compose (
      .mode      (mode_q),
      .style     (style_q),
      .invert    (inv_q),
      .fg_on     (fg_on),
      .shade     (lit_diag),
      .mesh_dark (mesh_dark),
      .fg        (attr.fg),
      .rgb       (cap_rgb),
      .blank     (cap_blank)
   );

   rgb_t nxt_rgb;
   logic nxt_blank;

   always_comb begin
      if (osd_blank) begin
         nxt_rgb   = osd_rgb;
         nxt_blank = 1'b1;
      end else begin
         nxt_rgb   = cap_rgb;
         nxt_blank = cap_blank;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_rgb   <= '0;
         vid_blank <= 1'b0;
      end else begin
         vid_rgb   <= nxt_rgb;
         vid_blank <= nxt_blank;
      end
   end

endmodule

// File: rtl/ccr_pixel_render_chk.sv
module ccr_pixel_render_chk #(
   parameter int XW      = 3,
   parameter int YW      = 4,
   parameter int GLYPH_H = 12
)(
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_q,
   input logic          inv_q,
   input logic [XW-1:0] pix_x,
   input logic [YW-1:0] pix_y,
   input logic [3:0]    attr_code,
   input logic          osd_blank,
   input logic [2:0]    osd_rgb,
   input logic [2:0]    vid_rgb,
   input logic          vid_blank
);

   logic boxed;
   assign boxed = (mode_q == 2'b01 || mode_q == 2'b10) && !osd_blank;

   p_overlay_r9: assert property (@(posedge clk) disable iff (!rst_n)
      osd_blank |=> (vid_blank && vid_rgb == $past(osd_rgb)));

   p_video_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && !osd_blank) |=>
         (vid_blank == $past(inv_q) && vid_rgb == {3{$past(inv_q)}}));

   p_top_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (boxed && !inv_q && pix_y == '0) |=> (vid_blank && vid_rgb == 3'b000));

   p_left_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (boxed && !inv_q && pix_x == '0 && pix_y != YW'(GLYPH_H)) |=>
         (vid_blank && vid_rgb == 3'b000));

   p_underline_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 2'b00 && !osd_blank && !inv_q && attr_code[0] &&
       pix_y == YW'(GLYPH_H)) |=> (vid_blank && vid_rgb != 3'b000));

   p_invert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (boxed && inv_q && pix_y == '0) |=> (!vid_blank && vid_rgb == 3'b111));

endmodule

bind ccr_pixel_render ccr_pixel_render_chk #(
   .XW (XW), .YW (YW), .GLYPH_H (GLYPH_H)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_q    (mode_q),
   .inv_q     (inv_q),
   .pix_x     (pix_x),
   .pix_y     (pix_y),
   .attr_code (attr_code),
   .osd_blank (osd_blank),
   .osd_rgb   (osd_rgb),
   .vid_rgb   (vid_rgb),
   .vid_blank (vid_blank)
);

// File: tb/ccr_pixel_render_bench.sv
`timescale 1ns/1ps
module ccr_pixel_render_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic [1:0] cfg_style = '0;
   logic       cfg_invert = 1'b0;
   logic [2:0] pix_x = '0;
   logic [3:0] pix_y = '0;
   logic [4:0] glyph_row = '0;
   logic [4:0] glyph_above = '0;
   logic [3:0] attr_code = '0;
   logic       osd_blank = 1'b0;
   logic [2:0] osd_rgb = '0;
   logic [2:0] vid_rgb;
   logic       vid_blank;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   ccr_pixel_render u_ccr_pixel_render (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_mode (cfg_mode),
      .cfg_style (cfg_style), .cfg_invert (cfg_invert), .pix_x (pix_x),
      .pix_y (pix_y), .glyph_row (glyph_row), .glyph_above (glyph_above),
      .attr_code (attr_code), .osd_blank (osd_blank), .osd_rgb (osd_rgb),
      .vid_rgb (vid_rgb), .vid_blank (vid_blank)
   );

   function automatic int pat(input int row, input int seed);
      return ((row * 11 + seed * 7 + 3) ^ (row >> 1)) & 31;
   endfunction

   function automatic int colour(input int sel);
      case (sel)
         0: return 7;  1: return 2;  2: return 1;  3: return 3;
         4: return 4;  5: return 6;  6: return 5;  default: return 7;
      endcase
   endfunction

   function automatic bit glyph_on(input int g, input int x, input int y, input bit ital);
      int sh, c;
      if (y < 1) return 0;
      sh = ital ? (12 - y) / 4 : 0;
      c  = x - 1 - sh;
      if (c < 0 || c > 4) return 0;
      return ((g >> (4 - c)) & 1) != 0;
   endfunction

   // returns {blank, rgb}
   function automatic logic [3:0] model(input int md, input int st, input int inv,
         input int x, input int y, input int gc, input int gp, input int at,
         input int eb, input int er);
      bit ital, lit, sd, b;
      int fg, r;
      if (eb != 0) return {1'b1, 3'(er)};
      ital = (at >> 1) == 7;
      fg   = colour(at >> 1);
      lit  = glyph_on(gc, x, y, ital) || ((at & 1) != 0 && y == 12);
      sd   = (x >= 1 && y >= 2) ? glyph_on(gp, x - 1, y - 1, ital) : 1'b0;
      r = 0; b = 0;
      if (md == 0) begin
         r = 0; b = 0;
      end else if (md == 1 || md == 2) begin
         r = lit ? fg : 0; b = 1;
      end else begin
         if (lit) begin r = fg; b = 1; end
         else if ((st & 2) == 0 && sd) b = 1;
         else if ((st & 1) != 0 && ((x + y) % 2) == 0) b = 1;
      end
      if (inv != 0) begin r = r ^ 7; b = ~b; end
      return {b, 3'(r)};
   endfunction

   function automatic string tag_of(input int md, input int st, input int inv,
         input int x, input int y, input int gp, input int at, input int eb);
      if (eb != 0) return "R9";
      if (md == 0) return "R5";
      if (inv != 0) return "R8";
      if ((at & 1) != 0 && y == 12) return "R3";
      if ((at >> 1) == 7) return "R4";
      if (md == 3 && (st & 2) == 0 && x >= 1 && y >= 2 &&
          glyph_on(gp, x - 1, y - 1, 0)) return "R7";
      if (md == 3) return "R6";
      if (x == 0 || y == 0) return "R1";
      return "R2";
   endfunction

   task automatic check(input string tag, input logic [3:0] exp);
      total++;
      if ({vid_blank, vid_rgb} !== exp) begin
         bad++;
         $display("FAIL %s: got blank=%b rgb=%b expected blank=%b rgb=%b t=%0t",
                  tag, vid_blank, vid_rgb, exp[3], exp[2:0], $time);
      end
   endtask

   task automatic load_cfg(input int md, input int st, input int inv);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mode = 2'(md); cfg_style = 2'(st); cfg_invert = 1'(inv);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive_px(input int x, input int y, input int seed, input int at,
                           input int eb, input int er);
      pix_x = 3'(x); pix_y = 4'(y); attr_code = 4'(at);
      glyph_row   = (y >= 1) ? 5'(pat(y - 1, seed)) : 5'h1F;
      glyph_above = (y >= 2) ? 5'(pat(y - 2, seed)) : 5'h1F;
      osd_blank = 1'(eb); osd_rgb = 3'(er);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] pend;
      string      ptag;
      bit         have;
      // R10: reset state
      #7;
      check("R10", 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      drive_px(3, 5, 1, 4, 0, 0);
      @(negedge clk);
      check("R10", 4'b0000);

      // full sweep
      for (int md = 0; md < 4; md++) begin
         for (int st = 0; st < 4; st++) begin
            for (int inv = 0; inv < 2; inv++) begin
               load_cfg(md, st, inv);
               have = 0;
               for (int at = 0; at < 16; at++) begin
                  for (int y = 0; y < 13; y++) begin
                     for (int x = 0; x < 7; x++) begin
                        int eb, er, seed;
                        seed = at + md * 3 + st;
                        eb = (((x + y + at + md) % 9) == 0) ? 1 : 0;
                        er = (x * 3 + y) & 7;
                        @(negedge clk);
                        if (have) check(ptag, pend);
                        drive_px(x, y, seed, at, eb, er);
                        pend = model(md, st, inv, x, y, pat(y - 1, seed),
                                     pat(y - 2, seed), at, eb, er);
                        ptag = tag_of(md, st, inv, x, y, pat(y - 2, seed), at, eb);
                        have = 1;
                     end
                  end
               end
               @(negedge clk);
               check(ptag, pend);
            end
         end
      end

      // R11: one-clock latency
      load_cfg(2, 0, 0);
      drive_px(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      check("R11", 4'b1000);
      drive_px(0, 0, 0, 0, 1, 5);
      #1;
      check("R11", 4'b1000);
      @(negedge clk);
      check("R11", 4'b1101);

      // R10: configuration ignored without the load strobe
      cfg_mode = 2'b00; cfg_invert = 1'b1; cfg_we = 1'b0;
      drive_px(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      check("R10", 4'b1000);

      // R10: reset mid-run returns to video only
      rst_n = 1'b0;
      #1;
      check("R10", 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      drive_px(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      check("R10", 4'b0000);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule